// File: doc/BRIEF.md
# Touch Panel Measurement Timing Sequencer

This block times one measurement pass of a resistive touch panel. It counts in ticks of a free-running 4 MHz oscillator, which arrive as a one-cycle enable on the system clock. A start request takes a snapshot of the configuration and then runs five phases in a fixed order. First the panel pin capacitance is precharged. Next comes a single-tick pen-touch sense. The panel drivers are then switched on for a settling wait. The conversion phase follows, with the drivers still on. Last comes a wait before the panel is sensed again. Each wait length is picked by a 3-bit code from a nonlinear table rather than counted linearly.

During conversion the block produces an enable for the ADC clock. This enable divides the oscillator tick by 1, 2 or 4. The ADC is modelled only as a busy interval of one ADC clock per result bit. The result width is 10 or 12 bits. A one-cycle done pulse marks the end of the pass. Configurations that cannot be honoured are replaced by a legal setting and reported through a sticky error flag.

Top module: `touch_meas_seq`

## Requirements
- R1: After reset, every phase output, `done_o`, `busy_o`, `adc_clk_en_o` and `cfg_err_o` is low.
- R2: Phases follow the order precharge, sense, settle, convert, post-wait. At most one of `precharge_o`, `sense_o`, `drv_en_o`, `post_wait_o` is high in any cycle.
- R3: The precharge phase lasts a number of ticks set by `pre_code_i`. Codes 0..7 give 80, 336, 1104, 1360, 4176, 4432, 5200 and 5456 ticks (20 µs to 1.364 ms).
- R4: `sense_o` is high for exactly one tick, between precharge and settle.
- R5: The settle phase has the drivers on and the conversion off. It lasts max(N,1) ticks, where `pvs_code_i` codes 0..7 give N = 0, 400, 2000, 4000, 20000, 40000, 200000 and 400000 ticks. With code 0, `conv_start_o` pulses in the cycle after `drv_en_o` rises. `conv_start_o` is a single pulse in the first conversion cycle.
- R6: `clk_sel_i` sets the ADC clock division: 00 divides by 1, 01 by 2 and 10 by 4. `res_10b_i`=1 selects 10 bits and 0 selects 12. The conversion gives exactly one `adc_clk_en_o` pulse per result bit, spaced by the division, and lasts bits × division ticks.
- R7: `clk_sel_i`=11 runs as divide-by-4, and 00 with 12 bits runs as divide-by-2. Either one, taken at start, sets `cfg_err_o`, which then stays high until reset.
- R8: The post-wait lasts a number of ticks set by `sns_code_i`. Codes 0..7 give 128, 384, 2176, 8320, 10624, 10880, 12928 and 16512 ticks. `done_o` then pulses for one cycle, with `busy_o` already low.
- R9: A `start_i` that arrives while a pass is running is ignored. The pass is not restarted and produces exactly one done pulse.
- R10: While `osc_tick_i` is low, a running pass does not advance.
- R11: The configuration is captured when a start is accepted. Changes to the configuration inputs during a pass have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle 4 MHz oscillator tick enable |
| start_i | input | 1 | Start request; accepted only when idle |
| clk_sel_i | input | 2 | ADC clock division select |
| res_10b_i | input | 1 | 1 = 10-bit result, 0 = 12-bit result |
| pre_code_i | input | 3 | Precharge time code |
| pvs_code_i | input | 3 | Settling time code |
| sns_code_i | input | 3 | Post-conversion sense wait code |
| precharge_o | output | 1 | Precharge phase active |
| sense_o | output | 1 | Pen-touch sense tick |
| drv_en_o | output | 1 | Panel drivers on (settle and convert) |
| conv_start_o | output | 1 | Pulse in the first conversion cycle |
| conv_busy_o | output | 1 | Conversion interval active |
| adc_clk_en_o | output | 1 | Divided ADC clock enable |
| post_wait_o | output | 1 | Post-conversion sense wait active |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| busy_o | output | 1 | Pass in progress |
| cfg_err_o | output | 1 | Sticky illegal clock-configuration flag |

## Verification
Several properties are checked on every cycle by assertions. These are the exclusivity of the phase strobes and the single-cycle done pulse with busy low. They also cover the spacing of ADC enables under division, the stickiness of the error flag, the freeze while no tick arrives, the conversion start falling inside conversion, and the rule that a running pass never re-enters precharge. The bench scenarios are needed for the lengths themselves: each table entry for precharge, settle and post-wait, the settle-to-start distance for code 0, and the exact count of ADC pulses for each division and resolution. The scenarios also show that start requests and configuration changes made during a pass leave these lengths unchanged.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
package tseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SENSE, ST_SETTLE, ST_CONV, ST_POST
  } tseq_state_e;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic       res_10b;
    logic [2:0] pre_code;
    logic [2:0] pvs_code;
    logic [2:0] sns_code;
  } tseq_cfg_t;

  // delay tables in 4 MHz ticks
  localparam int unsigned PRE_TICKS [8] = '{80, 336, 1104, 1360, 4176, 4432, 5200, 5456};
  localparam int unsigned PVS_TICKS [8] = '{0, 400, 2000, 4000, 20000, 40000, 200000, 400000};
  // replaceable sense-wait table
  localparam int unsigned SNS_TICKS [8] = '{128, 384, 2176, 8320, 10624, 10880, 12928, 16512};

  // effective log2 division; illegal selections fall back to a legal one
  function automatic logic [1:0] eff_div_log2(input logic [1:0] sel, input logic res_10b);
    case (sel)
      2'b00:   eff_div_log2 = res_10b ? 2'd0 : 2'd1;
      2'b01:   eff_div_log2 = 2'd1;
      default: eff_div_log2 = 2'd2;
    endcase
  endfunction

  function automatic logic cfg_is_bad(input logic [1:0] sel, input logic res_10b);
    cfg_is_bad = (sel == 2'b11) || (sel == 2'b00 && !res_10b);
  endfunction

endpackage

// File: rtl/tseq_delay_lut.sv
`timescale 1ns/1ps
module tseq_delay_lut
  import tseq_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input  tseq_state_e      phase_i,
  input  logic [2:0]       pre_code_i,
  input  logic [2:0]       pvs_code_i,
  input  logic [2:0]       sns_code_i,
  output logic [CNT_W-1:0] ticks_o
);

  always_comb begin
    case (phase_i)
      ST_PRE:    ticks_o = CNT_W'(PRE_TICKS[pre_code_i]);
      ST_SETTLE: ticks_o = CNT_W'(PVS_TICKS[pvs_code_i]);
      ST_POST:   ticks_o = CNT_W'(SNS_TICKS[sns_code_i]);
      default:   ticks_o = '0;
    endcase
  end

endmodule

// File: rtl/tseq_timer.sv
`timescale 1ns/1ps
module tseq_timer #(
  parameter int CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  // zero-length and one-tick loads both end on the next tick
  assign last_o = (cnt_q <= CNT_W'(1));

  // R10
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/tseq_adc_div.sv
`timescale 1ns/1ps
module tseq_adc_div #(
  parameter int BIT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [1:0]       div_log2_i,
  input  logic [BIT_W-1:0] bits_i,
  output logic             adc_en_o,
  output logic             conv_last_o
);

  logic [1:0]       div_cnt_q;
  logic [1:0]       mask;
  logic [BIT_W-1:0] bit_cnt_q;

  always_comb begin
    case (div_log2_i)
      2'd0:    mask = 2'b00;
      2'd1:    mask = 2'b01;
      default: mask = 2'b11;
    endcase
  end

  assign adc_en_o    = run_i && tick_i && ((div_cnt_q & mask) == mask);
  assign conv_last_o = adc_en_o && (bit_cnt_q == bits_i - BIT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      bit_cnt_q <= '0;
    end else if (!run_i) begin
      div_cnt_q <= '0;
      bit_cnt_q <= '0;
    end else begin
      if (tick_i)   div_cnt_q <= div_cnt_q + 2'd1;
      if (adc_en_o) bit_cnt_q <= bit_cnt_q + BIT_W'(1);
    end
  end

  // R6
  adc_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_en_o && div_log2_i != 2'd0) |=> !adc_en_o);

endmodule

// File: rtl/touch_meas_seq.sv
`timescale 1ns/1ps
module touch_meas_seq
  import tseq_pkg::*;
#(
  parameter int CNT_W  = 19,  // must hold the largest table entry (400000)
  parameter int RES_HI = 12,
  parameter int RES_LO = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       start_i,
  input  logic [1:0] clk_sel_i,
  input  logic       res_10b_i,
  input  logic [2:0] pre_code_i,
  input  logic [2:0] pvs_code_i,
  input  logic [2:0] sns_code_i,
  output logic       precharge_o,
  output logic       sense_o,
  output logic       drv_en_o,
  output logic       conv_start_o,
  output logic       conv_busy_o,
  output logic       adc_clk_en_o,
  output logic       post_wait_o,
  output logic       done_o,
  output logic       busy_o,
  output logic       cfg_err_o
);

  localparam int BIT_W = $clog2(RES_HI + 1);

  tseq_state_e      state_q, state_d;
  tseq_cfg_t        cfg_q, cfg_in, cfg_sel;
  logic             accept;
  logic             tmr_last, conv_last, adc_en;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done_q, conv_start_q, cfg_err_q;
  logic [1:0]       div_log2;
  logic [BIT_W-1:0] bits;

  assign cfg_in  = '{clk_sel: clk_sel_i, res_10b: res_10b_i, pre_code: pre_code_i,
                     pvs_code: pvs_code_i, sns_code: sns_code_i};
  assign cfg_sel = (state_q == ST_IDLE) ? cfg_in : cfg_q;
  assign accept  = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i)                 state_d = ST_PRE;
      ST_PRE:    if (osc_tick_i && tmr_last)  state_d = ST_SENSE;
      ST_SENSE:  if (osc_tick_i)              state_d = ST_SETTLE;
      ST_SETTLE: if (osc_tick_i && tmr_last)  state_d = ST_CONV;
      ST_CONV:   if (conv_last)               state_d = ST_POST;
      ST_POST:   if (osc_tick_i && tmr_last)  state_d = ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  assign load = (state_d != state_q);

  tseq_delay_lut #(.CNT_W(CNT_W)) u_lut (
    .phase_i    (state_d),
    .pre_code_i (cfg_sel.pre_code),
    .pvs_code_i (cfg_sel.pvs_code),
    .sns_code_i (cfg_sel.sns_code),
    .ticks_o    (load_val)
  );

  tseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (osc_tick_i),
    .last_o     (tmr_last)
  );

  assign div_log2 = eff_div_log2(cfg_q.clk_sel, cfg_q.res_10b);
  assign bits     = cfg_q.res_10b ? BIT_W'(RES_LO) : BIT_W'(RES_HI);

  tseq_adc_div #(.BIT_W(BIT_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (state_q == ST_CONV),
    .tick_i      (osc_tick_i),
    .div_log2_i  (div_log2),
    .bits_i      (bits),
    .adc_en_o    (adc_en),
    .conv_last_o (conv_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cfg_q        <= '0;
      done_q       <= 1'b0;
      conv_start_q <= 1'b0;
      cfg_err_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      if (accept) cfg_q <= cfg_in;
      done_q       <= (state_q == ST_POST) && (state_d == ST_IDLE);
      conv_start_q <= (state_q == ST_SETTLE) && (state_d == ST_CONV);
      if (accept && cfg_is_bad(clk_sel_i, res_10b_i)) cfg_err_q <= 1'b1;
    end
  end

  assign precharge_o  = (state_q == ST_PRE);
  assign sense_o      = (state_q == ST_SENSE);
  assign drv_en_o     = (state_q == ST_SETTLE) || (state_q == ST_CONV);
  assign conv_busy_o  = (state_q == ST_CONV);
  assign conv_start_o = conv_start_q;
  assign adc_clk_en_o = adc_en;
  assign post_wait_o  = (state_q == ST_POST);
  assign done_o       = done_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign cfg_err_o    = cfg_err_q;

  // R2
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({precharge_o, sense_o, drv_en_o, post_wait_o}));

  // R5
  conv_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (conv_busy_o && drv_en_o));

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !$past(done_o)));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_PRE) |=> (state_q != ST_PRE));

  // R10
  tick_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_tick_i && state_q != ST_IDLE) |=> $stable(state_q));

endmodule

// File: tb/touch_meas_seq_tb.sv
`timescale 1ns/1ps
module touch_meas_seq_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_tick_i = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] clk_sel_i = 2'b01;
  logic       res_10b_i = 1'b1;
  logic [2:0] pre_code_i = '0, pvs_code_i = '0, sns_code_i = '0;
  logic precharge_o, sense_o, drv_en_o, conv_start_o, conv_busy_o;
  logic adc_clk_en_o, post_wait_o, done_o, busy_o, cfg_err_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit err_exp = 0;

  always #2.5 clk_i = ~clk_i;

  touch_meas_seq u_dut (
    .clk_i, .rst_ni, .osc_tick_i, .start_i, .clk_sel_i, .res_10b_i,
    .pre_code_i, .pvs_code_i, .sns_code_i,
    .precharge_o, .sense_o, .drv_en_o, .conv_start_o, .conv_busy_o,
    .adc_clk_en_o, .post_wait_o, .done_o, .busy_o, .cfg_err_o
  );

  function automatic int f_pre(input logic [2:0] c);
    int t [8] = '{80, 336, 1104, 1360, 4176, 4432, 5200, 5456};
    return t[c];
  endfunction
  function automatic int f_pvs(input logic [2:0] c);
    int t [8] = '{0, 400, 2000, 4000, 20000, 40000, 200000, 400000};
    return t[c];
  endfunction
  function automatic int f_sns(input logic [2:0] c);
    int t [8] = '{128, 384, 2176, 8320, 10624, 10880, 12928, 16512};
    return t[c];
  endfunction
  function automatic int f_div(input logic [1:0] s, input logic r10);
    if (s == 2'b00) return r10 ? 1 : 2;
    if (s == 2'b01) return 2;
    return 4;
  endfunction
  function automatic bit f_bad(input logic [1:0] s, input logic r10);
    return (s == 2'b11) || (s == 2'b00 && !r10);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic run_meas(input logic [1:0] sel, input logic r10, input logic [2:0] pc,
                          input logic [2:0] vc, input logic [2:0] sc,
                          input bit perturb, input bit freeze);
    int c_pre = 0, c_sen = 0, c_set = 0, c_conv = 0, c_adc = 0, c_cs = 0, c_post = 0;
    int idx = 0;
    int frz_bad = 0;
    int bits = r10 ? 10 : 12;
    int exp_pre = f_pre(pc) + (freeze ? 50 : 0);
    int exp_set = (f_pvs(vc) == 0) ? 1 : f_pvs(vc);
    bit got_done = 0;
    err_exp = err_exp | f_bad(sel, r10);
    @(negedge clk_i);
    clk_sel_i = sel; res_10b_i = r10; pre_code_i = pc; pvs_code_i = vc; sns_code_i = sc;
    osc_tick_i = 1'b1; start_i = 1'b1;
    while (!got_done && idx < 100000) begin
      @(negedge clk_i);
      idx++;
      if (precharge_o)  c_pre++;
      if (sense_o)      c_sen++;
      if (drv_en_o && !conv_busy_o) c_set++;
      if (conv_busy_o)  c_conv++;
      if (adc_clk_en_o) c_adc++;
      if (conv_start_o) c_cs++;
      if (post_wait_o)  c_post++;
      if (done_o)       got_done = 1;
      if (freeze && idx > 10 && idx <= 60 && (!precharge_o || sense_o)) frz_bad++;
      start_i = (perturb && !got_done) ? 1'($urandom % 2) : 1'b0;
      if (perturb) begin
        clk_sel_i = 2'($urandom); res_10b_i = 1'($urandom);
        pre_code_i = 3'($urandom); pvs_code_i = 3'($urandom); sns_code_i = 3'($urandom);
      end
      osc_tick_i = (freeze && idx >= 10 && idx < 60) ? 1'b0 : 1'b1;
    end
    start_i = 1'b0;
    chk("R8 done seen", int'(got_done), 1);
    chk(freeze ? "R10 precharge length with tick frozen" : "R3 precharge length", c_pre, exp_pre);
    if (freeze) chk("R10 frozen precharge held", frz_bad, 0);
    chk("R4 sense length", c_sen, 1);
    chk("R5 settle length", c_set, exp_set);
    chk("R5 conv_start count", c_cs, 1);
    chk("R6 conversion length", c_conv, bits * f_div(sel, r10));
    chk("R6 adc pulse count", c_adc, bits);
    chk(perturb ? "R11 post wait length under config churn" : "R8 post wait length",
        c_post, f_sns(sc));
    chk("R7 cfg_err state", int'(cfg_err_o), int'(err_exp));
    @(negedge clk_i);
    chk("R8 done single pulse", int'(done_o), 0);
    chk(perturb ? "R9 idle after pass despite starts" : "R8 idle after done", int'(busy_o), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs low in reset",
        int'({precharge_o, sense_o, drv_en_o, conv_start_o, conv_busy_o,
              adc_clk_en_o, post_wait_o, done_o, busy_o, cfg_err_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle after reset release", int'({busy_o, cfg_err_o}), 0);

    run_meas(2'b00, 1'b1, 3'd0, 3'd0, 3'd0, 0, 0); // div1 10-bit, zero settle
    run_meas(2'b01, 1'b0, 3'd7, 3'd4, 3'd7, 0, 0); // long tables
    run_meas(2'b10, 1'b1, 3'd3, 3'd1, 3'd2, 1, 0); // R9/R11 churn
    run_meas(2'b01, 1'b1, 3'd0, 3'd2, 3'd0, 0, 1); // R10 freeze
    run_meas(2'b00, 1'b0, 3'd1, 3'd0, 3'd1, 0, 0); // R7 div1 with 12-bit

    @(negedge clk_i); rst_ni = 1'b0; err_exp = 0;
    @(negedge clk_i);
    chk("R1 cfg_err cleared by reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_meas(2'b11, 1'b0, 3'd1, 3'd3, 3'd1, 0, 0); // R7 reserved select

    for (int i = 0; i < 6; i++) begin
      run_meas(2'($urandom), 1'($urandom), 3'($urandom), 3'($urandom % 4),
               3'($urandom % 3), 1'($urandom), 0);
    end
    finish_run();
  end

endmodule